// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, once per cycle, how an in-order five-stage pipeline moves: fetch, decode, execute, memory and writeback. It receives the register fields and operation flags that the datapath holds for each stage, together with the branch outcome that decode has already computed. From these it produces a fetch hold, a decode hold, bubble-insertion strobes for the decode and execute pipeline registers, a program-counter redirect, the grant of the one memory port that instruction fetch and data access share, the bypass selects for both execute operands, and a bypass strobe for store data in the memory stage.

The controller keeps its own valid bit for each of the four pipeline registers behind fetch (decode, execute, memory, writeback). Its hold and bubble decisions update these bits at the clock edge. A bubble is a stage whose valid bit is 0, and such a stage never causes a stall, a bypass or a port request. Branches are predicted not taken, so fetch always continues sequentially. When decode finds a taken branch, the single instruction fetched behind it is squashed.

Top module: `hz_ctrl`

## Requirements
- R1: An active-high synchronous reset clears all four valid bits (`stage_valid` bit 0 decode, bit 1 execute, bit 2 memory, bit 3 writeback). With no hazard present, each bit takes the value of the stage before it on every clock, and decode becomes valid whenever a fetch completes.
- R2: When the memory stage holds a valid load or store, the port is granted to data (`mem_grant_data`=1, `mem_grant_fetch`=0). In that cycle fetch holds (`if_stall_n`=0) and a bubble enters decode (`id_flush`=1). Instructions ahead of fetch keep moving.
- R3: A valid load in execute whose nonzero destination matches a source that a valid decode instruction uses causes a load-use stall. Fetch and decode hold (`if_stall_n`=0, `id_stall_n`=0), and a bubble enters execute (`ex_flush`=1). On the next clock, decode keeps its valid bit and execute becomes invalid.
- R4: The load-use stall also applies when the dependent instruction uses the loaded value as a base address (rs1), whether it is a load or a store. The data register (rs2) of a store in decode never triggers the stall.
- R5: None of the following stalls: an ALU producer in execute, register 0, an invalid execute or decode stage, or a writeback to the register that decode is reading in the same cycle.
- R6: Execute operand selects `fwd_a` (rs1) and `fwd_b` (rs2) use 0 for the register file, 1 for the memory-stage result and 2 for the writeback-stage result. The memory stage wins when both stages match. Only valid, writing, nonzero destinations are bypassed.
- R7: `st_fwd` is 1 exactly when a valid store in memory has a nonzero data register that equals the destination of a valid writing instruction in writeback.
- R8: A valid taken branch in decode that is not stalled raises `pc_redirect` and `id_flush`. On the next clock, decode is invalid and the branch is valid in execute. The redirect takes priority over a fetch hold. A branch under a load-use stall does not redirect.
- R9: A not-taken branch causes neither redirect nor flush, and fetch continues sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| id_rs1 | input | REG_W | Decode source register 1 (base address) |
| id_rs2 | input | REG_W | Decode source register 2 (store data) |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store |
| id_is_branch | input | 1 | Decode instruction is a branch |
| id_br_taken | input | 1 | Branch outcome resolved in decode |
| ex_rs1 | input | REG_W | Execute operand A register |
| ex_rs2 | input | REG_W | Execute operand B register |
| ex_rd | input | REG_W | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_rs2 | input | REG_W | Memory-stage store data register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | REG_W | Writeback destination register |
| wb_we | input | 1 | Writeback instruction writes a register |
| stage_valid | output | 4 | Valid bits: decode, execute, memory, writeback (bit 0 to 3) |
| if_stall_n | output | 1 | Fetch may advance the PC (0 = hold) |
| id_stall_n | output | 1 | Decode register may load (0 = hold) |
| id_flush | output | 1 | Load a bubble into decode |
| ex_flush | output | 1 | Load a bubble into execute |
| pc_redirect | output | 1 | Load the branch target into the PC |
| mem_grant_fetch | output | 1 | Memory port serves instruction fetch |
| mem_grant_data | output | 1 | Memory port serves the memory stage |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| st_fwd | output | 1 | Bypass writeback result to store data |

## Verification
The bench goes after the places where two hazards meet. A controller that checked the rs2 of a store would stall a load-to-store data pair that the writeback bypass already covers. One that lacked bypass priority would hand execute a stale writeback value when both later stages target the same register. One that let a stalled branch redirect would squash the wrong instruction. The bench also follows the valid bits for two cycles after each stall, squash and port conflict. A design that held the wrong stage, or dropped the instruction held in decode instead of placing a bubble behind it, would lose or duplicate an instruction. The bench then steps out of reset with a matching load already on the fields, where a design that ignored its own valid bits would stall on empty stages.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  localparam int N_TRACK = 4;
  localparam int ST_ID   = 0;
  localparam int ST_EX   = 1;
  localparam int ST_MEM  = 2;
  localparam int ST_WB   = 3;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             ex_ok,
  input  logic             mem_ok,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_ok,
  input  logic [REG_W-1:0] wb_rd,
  output fwd_sel_e         sel
);
  function automatic logic producer_hit(input logic ok, input logic [REG_W-1:0] rd,
                                        input logic [REG_W-1:0] rs);
    return ok && (rd != '0) && (rd == rs);
  endfunction

  always_comb begin
    sel = FWD_RF;
    if (ex_ok) begin
      if (producer_hit(mem_ok, mem_rd, src))     sel = FWD_MEM;
      else if (producer_hit(wb_ok, wb_rd, src))  sel = FWD_WB;
    end
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic             id_v,
  input  logic             ex_v,
  input  logic             mem_v,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_is_store,
  input  logic             id_is_branch,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic             mem_is_load,
  input  logic             mem_is_store,
  output logic             load_use,
  output logic             mem_busy,
  output logic             redirect
);
  function automatic logic reads_reg(input logic used, input logic [REG_W-1:0] rs,
                                     input logic [REG_W-1:0] rd);
    return used && (rd != '0) && (rs == rd);
  endfunction

  logic base_dep, data_dep;

  always_comb begin
    base_dep = reads_reg(id_use_rs1, id_rs1, ex_rd);
    // store data reaches memory late enough for the writeback bypass
    data_dep = reads_reg(id_use_rs2 && !id_is_store, id_rs2, ex_rd);
    load_use = id_v && ex_v && ex_is_load && ex_we && (base_dep || data_dep);
    mem_busy = mem_v && (mem_is_load || mem_is_store);
    redirect = id_v && id_is_branch && id_br_taken && !load_use;
  end
endmodule

// File: rtl/hz_valid_pipe.sv
module hz_valid_pipe #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         id_in,
  input  logic         id_hold,
  input  logic         ex_kill,
  output logic [N-1:0] v
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
    end else begin
      v[0] <= id_hold ? v[0] : id_in;
      v[1] <= ex_kill ? 1'b0 : v[0];
      for (int i = 2; i < N; i++) v[i] <= v[i-1];
    end
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_is_store,
  input  logic             id_is_branch,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic [REG_W-1:0] mem_rs2,
  input  logic             mem_we,
  input  logic             mem_is_load,
  input  logic             mem_is_store,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [3:0]       stage_valid,
  output logic             if_stall_n,
  output logic             id_stall_n,
  output logic             id_flush,
  output logic             ex_flush,
  output logic             pc_redirect,
  output logic             mem_grant_fetch,
  output logic             mem_grant_data,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             st_fwd
);
  localparam int NOPS = 2;

  logic [N_TRACK-1:0] v;
  logic load_use_hit, mem_busy, branch_redirect, fetch_lands;

  hz_stall_unit #(.REG_W(REG_W)) u_stall (
    .id_v(v[ST_ID]), .ex_v(v[ST_EX]), .mem_v(v[ST_MEM]),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_is_store), .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .load_use(load_use_hit), .mem_busy(mem_busy), .redirect(branch_redirect)
  );

  // an instruction reaches decode only if the port served fetch and no squash hit it
  assign fetch_lands = !mem_busy && !branch_redirect;

  hz_valid_pipe #(.N(N_TRACK)) u_valid (
    .clk(clk), .rst(rst),
    .id_in(fetch_lands), .id_hold(load_use_hit), .ex_kill(load_use_hit),
    .v(v)
  );

  logic [REG_W-1:0] ex_src [NOPS];
  fwd_sel_e         fsel   [NOPS];
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NOPS; g++) begin : g_fwd
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src(ex_src[g]), .ex_ok(v[ST_EX]),
      .mem_ok(v[ST_MEM] && mem_we), .mem_rd(mem_rd),
      .wb_ok(v[ST_WB] && wb_we), .wb_rd(wb_rd),
      .sel(fsel[g])
    );
  end

  assign fwd_a = fsel[0];
  assign fwd_b = fsel[1];

  assign stage_valid     = v;
  assign if_stall_n      = !(load_use_hit || mem_busy);
  assign id_stall_n      = !load_use_hit;
  assign id_flush        = !load_use_hit && !fetch_lands;
  assign ex_flush        = load_use_hit;
  assign pc_redirect     = branch_redirect;
  assign mem_grant_data  = mem_busy;
  assign mem_grant_fetch = !mem_busy;
  assign st_fwd = v[ST_MEM] && mem_is_store && v[ST_WB] && wb_we &&
                  (wb_rd != '0) && (wb_rd == mem_rs2);
endmodule

// File: rtl/hz_ctrl_checker.sv
module hz_ctrl_checker #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] ex_rs1,
  input logic [3:0]       stage_valid,
  input logic             id_stall_n,
  input logic             ex_flush,
  input logic             pc_redirect,
  input logic             mem_grant_data,
  input logic [1:0]       fwd_a,
  input logic             st_fwd
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_wb_follows_mem: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> stage_valid[3] == $past(stage_valid[2]));

  a_r2_port_conflict_bubble: assert property (@(posedge clk) disable iff (rst)
    (mem_grant_data && id_stall_n) |=> !stage_valid[0]);

  a_r3_execute_bubble: assert property (@(posedge clk) disable iff (rst)
    ex_flush |=> !stage_valid[1]);

  a_r3_decode_kept: assert property (@(posedge clk) disable iff (rst)
    (!id_stall_n && stage_valid[0]) |=> stage_valid[0]);

  a_r6_no_reg0_bypass: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd0) |-> (ex_rs1 != '0));

  a_r7_store_needs_valid: assert property (@(posedge clk) disable iff (rst)
    st_fwd |-> (stage_valid[2] && stage_valid[3]));

  a_r8_squash: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |=> !stage_valid[0]);
endmodule

bind hz_ctrl hz_ctrl_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .ex_rs1(ex_rs1), .stage_valid(stage_valid),
  .id_stall_n(id_stall_n), .ex_flush(ex_flush), .pc_redirect(pc_redirect),
  .mem_grant_data(mem_grant_data), .fwd_a(fwd_a), .st_fwd(st_fwd)
);

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [REG_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_use_rs1, id_use_rs2, id_is_store, id_is_branch, id_br_taken;
  logic ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we;
  logic [3:0] stage_valid;
  logic if_stall_n, id_stall_n, id_flush, ex_flush, pc_redirect;
  logic mem_grant_fetch, mem_grant_data, st_fwd;
  logic [1:0] fwd_a, fwd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hz_ctrl #(.REG_W(REG_W)) u_hz_ctrl (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_is_store), .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_rs2(mem_rs2), .mem_we(mem_we),
    .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .wb_rd(wb_rd), .wb_we(wb_we),
    .stage_valid(stage_valid), .if_stall_n(if_stall_n), .id_stall_n(id_stall_n),
    .id_flush(id_flush), .ex_flush(ex_flush), .pc_redirect(pc_redirect),
    .mem_grant_fetch(mem_grant_fetch), .mem_grant_data(mem_grant_data),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_fields();
    id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0;
    id_is_store = 0; id_is_branch = 0; id_br_taken = 0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_we = 0; ex_is_load = 0;
    mem_rd = '0; mem_rs2 = '0; mem_we = 0; mem_is_load = 0; mem_is_store = 0;
    wb_rd = '0; wb_we = 0;
  endtask

  // next negedge, then settle
  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic after_clock();
    @(posedge clk); #1;
  endtask

  // reset and run hazard-free until all four stages are valid
  task automatic prime();
    drive_edge(); rst = 1; clear_fields();
    after_clock(); after_clock();
    drive_edge(); rst = 0;
    repeat (4) after_clock();
  endtask

  task automatic t_reset();
    drive_edge(); rst = 1; clear_fields();
    after_clock(); after_clock();
    check("R1", "valid bits under reset", stage_valid, 4'b0000);
    drive_edge(); rst = 0;
    after_clock();
    check("R1", "decode valid after first fetch", stage_valid, 4'b0001);
    after_clock(); after_clock(); after_clock();
    check("R1", "pipeline filled", stage_valid, 4'b1111);
  endtask

  task automatic t_forward();
    prime();
    drive_edge();
    mem_rd = 3; mem_we = 1; ex_rs1 = 3; wb_rd = 4; wb_we = 1; ex_rs2 = 4;
    #2;
    check("R6", "operand A from memory stage", fwd_a, 1);
    check("R6", "operand B from writeback", fwd_b, 2);
    wb_rd = 3; ex_rs2 = 3; #2;
    check("R6", "memory stage wins over writeback", fwd_b, 1);
    mem_rd = 0; wb_rd = 0; ex_rs1 = 0; ex_rs2 = 0; #2;
    check("R6", "register 0 never bypassed", fwd_a, 0);
    mem_we = 0; mem_rd = 3; wb_rd = 3; ex_rs1 = 3; #2;
    check("R6", "non-writing memory stage skipped", fwd_a, 2);
    clear_fields();
  endtask

  task automatic t_load_use();
    prime();
    drive_edge();
    ex_is_load = 1; ex_we = 1; ex_rd = 5; id_rs1 = 5; id_use_rs1 = 1; #2;
    check("R3", "fetch held", if_stall_n, 0);
    check("R3", "decode held", id_stall_n, 0);
    check("R3", "execute bubble", ex_flush, 1);
    check("R3", "no decode bubble", id_flush, 0);
    after_clock();
    check("R3", "valid after stall", stage_valid, 4'b1101);
    drive_edge(); clear_fields(); #2;
    check("R3", "stall lasts one cycle", id_stall_n, 1);
    after_clock();
    check("R3", "bubble moves to memory", stage_valid, 4'b1011);
  endtask

  task automatic t_load_base();
    prime();
    drive_edge();
    ex_is_load = 1; ex_we = 1; ex_rd = 6; id_rs1 = 6; id_use_rs1 = 1; #2;
    check("R4", "load base from load stalls", id_stall_n, 0);
    id_is_store = 1; id_rs1 = 2; id_rs2 = 6; id_use_rs2 = 1; #2;
    check("R4", "store data from load no stall", id_stall_n, 1);
    check("R4", "store data no execute bubble", ex_flush, 0);
    id_rs1 = 6; #2;
    check("R4", "store base from load stalls", id_stall_n, 0);
    clear_fields();
  endtask

  task automatic t_no_stall();
    prime();
    drive_edge();
    ex_we = 1; ex_rd = 5; id_rs1 = 5; id_use_rs1 = 1; #2;
    check("R5", "ALU producer no stall", id_stall_n, 1);
    ex_is_load = 1; ex_rd = 0; id_rs1 = 0; #2;
    check("R5", "register 0 no stall", id_stall_n, 1);
    ex_rd = 9; wb_rd = 5; wb_we = 1; id_rs1 = 5; #2;
    check("R5", "same-cycle writeback no stall", id_stall_n, 1);
    drive_edge(); rst = 1; clear_fields();
    after_clock();
    drive_edge(); rst = 0;
    ex_is_load = 1; ex_we = 1; ex_rd = 5; id_rs1 = 5; id_use_rs1 = 1; #2;
    check("R5", "invalid stages no stall", id_stall_n, 1);
    clear_fields();
  endtask

  task automatic t_struct();
    prime();
    drive_edge();
    mem_is_load = 1; #2;
    check("R2", "data grant on load", mem_grant_data, 1);
    check("R2", "fetch denied", mem_grant_fetch, 0);
    check("R2", "fetch held", if_stall_n, 0);
    check("R2", "decode bubble", id_flush, 1);
    check("R2", "decode not held", id_stall_n, 1);
    after_clock();
    check("R2", "bubble in decode", stage_valid, 4'b1110);
    drive_edge(); mem_is_load = 0; mem_is_store = 1; #2;
    check("R2", "data grant on store", mem_grant_data, 1);
    drive_edge(); clear_fields(); #2;
    check("R2", "port back to fetch", mem_grant_fetch, 1);
  endtask

  task automatic t_branch();
    prime();
    drive_edge();
    id_is_branch = 1; id_br_taken = 0; #2;
    check("R9", "not taken no redirect", pc_redirect, 0);
    check("R9", "not taken no flush", id_flush, 0);
    check("R9", "not taken fetch continues", if_stall_n, 1);
    after_clock();
    check("R9", "not taken valid", stage_valid, 4'b1111);
    drive_edge(); id_br_taken = 1; #2;
    check("R8", "taken redirect", pc_redirect, 1);
    check("R8", "taken squash", id_flush, 1);
    after_clock();
    check("R8", "wrong path squashed", stage_valid, 4'b1110);
    drive_edge(); clear_fields();
    after_clock();
    check("R8", "squash bubble in execute", stage_valid, 4'b1101);
    after_clock();
    drive_edge();
    id_is_branch = 1; id_br_taken = 1;
    ex_is_load = 1; ex_we = 1; ex_rd = 5; id_rs1 = 5; id_use_rs1 = 1; #2;
    check("R8", "stalled branch no redirect", pc_redirect, 0);
    clear_fields();
  endtask

  task automatic t_store_fwd();
    prime();
    drive_edge();
    mem_is_store = 1; mem_rs2 = 7; wb_rd = 7; wb_we = 1; #2;
    check("R7", "store data bypass", st_fwd, 1);
    wb_rd = 8; #2;
    check("R7", "mismatch no bypass", st_fwd, 0);
    wb_rd = 0; mem_rs2 = 0; #2;
    check("R7", "register 0 no bypass", st_fwd, 0);
    wb_rd = 7; mem_rs2 = 7; mem_is_store = 0; #2;
    check("R7", "non-store no bypass", st_fwd, 0);
    clear_fields();
  endtask

  initial begin
    clear_fields();
    t_reset();
    t_forward();
    t_load_use();
    t_load_base();
    t_no_stall();
    t_struct();
    t_branch();
    t_store_fwd();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule